// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block turns two request sources into a clean processor reset. The first is a digital flag that an external comparator raises while the supply is under its threshold. The second is an active-low manual-reset line, such as a push-button. Reset stays asserted while either request is present. Once every request has gone away, a down-counter keeps reset asserted for a programmed number of clock cycles and then lets it go.

A new request that arrives while the counter is still running stretches the pulse. The remaining count is raised to a guaranteed minimum, or kept if it is already larger. That minimum width also serves as the only debounce for the manual-reset button. Both polarities of reset are driven, and a status copy of the active-high reset is provided for a watchdog.

The control is a three-state machine:

- `ST_HOLD`: a request is present, reset is asserted and the counter is frozen.
- `ST_TIMING`: there is no request, reset is asserted and the counter decrements.
- `ST_RUN`: reset is released.

The transitions are:

- HOLD→TIMING when the request clears.
- TIMING→HOLD when a request arrives; the counter is stretched to at least the minimum.
- TIMING→RUN when the count expires.
- RUN→HOLD when a request arrives; the counter is reloaded to the full delay.

Both request inputs pass through two-flop synchronisers. Durations are parameters in clock cycles.

Top module: `rst_pulse_gen`

## Requirements
- R1: While `por_n` is low, and on the first cycles after it rises, `rst_n_o` is 0. The counter starts loaded with RELEASE_CYC.
- R2: As long as `supply_low` stays 1, `rst_n_o` stays 0.
- R3: After `supply_low` falls, `rst_n_o` rises exactly RELEASE_CYC+3 clock edges later. The 3 edges are two synchroniser flops and one state flop.
- R4: Suppose a request ends while a pulse is running and fewer than MIN_CYC cycles of the count remain. Then `rst_n_o` rises exactly MIN_CYC+3 edges after the request input clears.
- R5: Suppose a request ends while a pulse is running and R ≥ MIN_CYC cycles of the count remain. Then the count R is kept, and `rst_n_o` rises R+3 edges after the request input clears.
- R6: A request lasting a single clock period while reset is released produces a full pulse. `rst_n_o` rises RELEASE_CYC+3 edges after the input clears.
- R7: `mr_n` = 0 is a request with the same effect as `supply_low` = 1. This covers holding reset, loading the full delay from the released state, and stretching to the minimum during a pulse.
- R8: `rst_o` is always the complement of `rst_n_o`, and `reset_active` always equals `rst_o`.
- R9: When reset is released, `rst_n_o` falls exactly 3 clock edges after a request input becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| supply_low | input | 1 | 1 while the supply is under its threshold |
| mr_n | input | 1 | Manual reset request, active low |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |
| reset_active | output | 1 | Status copy of `rst_o` for a watchdog |

## Verification
The main function is driven with several request patterns. A long supply-low hold followed by recovery exposes the full release delay and the synchroniser latency. A one-cycle glitch from the released state shows that even the shortest request yields a full pulse. Two brownouts placed early and late inside a running pulse separate the "keep the larger remaining count" path from the "raise to the minimum" path. Manual-reset presses, both from the released state and as a short tap during a pulse, show that the button follows the same rules as the supply flag.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_TIMING = 2'd1,
        ST_RUN    = 2'd2
    } rpg_state_e;
endpackage

// File: rtl/rpg_sync.sv
module rpg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic por_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sr <= {STAGES{RST_VAL}};
        end else begin
            sr[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                sr[i] <= sr[i-1];
            end
        end
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/rpg_timer.sv
module rpg_timer #(
    parameter int RELEASE_CYC = 20,
    parameter int MIN_CYC     = 12,
    parameter int CNT_W       = $clog2(RELEASE_CYC + 1)
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             load_full,
    input  logic             stretch,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    localparam logic [CNT_W-1:0] FULL_V = CNT_W'(RELEASE_CYC);
    localparam logic [CNT_W-1:0] MIN_V  = CNT_W'(MIN_CYC);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt <= FULL_V;
        end else if (load_full) begin
            cnt <= FULL_V;
        end else if (stretch) begin
            if (cnt < MIN_V) begin
                cnt <= MIN_V;
            end
        end else if (dec) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
    parameter int RELEASE_CYC = 6554,
    parameter int MIN_CYC     = 4588,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic supply_low,
    input  logic mr_n,
    output logic rst_n_o,
    output logic rst_o,
    output logic reset_active
);
    import rpg_pkg::*;

    localparam int CNT_W = $clog2(RELEASE_CYC + 1);

    logic             low_s;
    logic             mr_n_s;
    logic             trig;
    logic             load_full;
    logic             stretch;
    logic             dec;
    logic             last;
    logic [CNT_W-1:0] cnt;
    logic             rst_q;
    rpg_state_e       state;
    rpg_state_e       state_nx;

    rpg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_low (
        .clk(clk), .por_n(por_n), .d(supply_low), .q(low_s)
    );

    rpg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_mr (
        .clk(clk), .por_n(por_n), .d(mr_n), .q(mr_n_s)
    );

    assign trig = low_s | ~mr_n_s;

    // Next-state and counter control
    always_comb begin
        state_nx  = state;
        load_full = 1'b0;
        stretch   = 1'b0;
        dec       = 1'b0;
        unique case (state)
            ST_HOLD: begin
                if (!trig) state_nx = ST_TIMING;
            end
            ST_TIMING: begin
                if (trig) begin
                    state_nx = ST_HOLD;
                    stretch  = 1'b1;
                end else if (last) begin
                    state_nx = ST_RUN;
                end else begin
                    dec = 1'b1;
                end
            end
            ST_RUN: begin
                if (trig) begin
                    state_nx  = ST_HOLD;
                    load_full = 1'b1;
                end
            end
            default: state_nx = ST_HOLD;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_HOLD;
        else        state <= state_nx;
    end

    // Output register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) rst_q <= 1'b1;
        else        rst_q <= (state_nx != ST_RUN);
    end

    rpg_timer #(
        .RELEASE_CYC(RELEASE_CYC), .MIN_CYC(MIN_CYC), .CNT_W(CNT_W)
    ) u_timer (
        .clk(clk), .por_n(por_n), .load_full(load_full), .stretch(stretch),
        .dec(dec), .cnt(cnt), .last(last)
    );

    assign rst_o        = rst_q;
    assign rst_n_o      = ~rst_q;
    assign reset_active = rst_q;
endmodule

// File: rtl/rpg_checker.sv
module rpg_checker
    import rpg_pkg::*;
#(
    parameter int RELEASE_CYC = 20,
    parameter int MIN_CYC     = 12,
    parameter int CNT_W       = 5
) (
    input logic             clk,
    input logic             por_n,
    input logic             trig,
    input rpg_state_e       state,
    input logic [CNT_W-1:0] cnt,
    input logic             rst_o,
    input logic             rst_n_o,
    input logic             reset_active
);
    // R8
    polarity_pair_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rst_o == !rst_n_o) && (reset_active == rst_o));

    // R2
    request_holds_chk: assert property (@(posedge clk) disable iff (!por_n)
        trig |=> rst_o);

    // R3
    release_at_one_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_o) |-> ($past(cnt) == CNT_W'(1)));

    // R4
    stretch_min_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_TIMING && trig && cnt < CNT_W'(MIN_CYC)) |=> (cnt == CNT_W'(MIN_CYC)));

    // R5
    stretch_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_TIMING && trig && cnt >= CNT_W'(MIN_CYC)) |=> $stable(cnt));

    // R6
    run_reload_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_RUN && trig) |=> (cnt == CNT_W'(RELEASE_CYC)));

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cnt >= CNT_W'(1)) && (cnt <= CNT_W'(RELEASE_CYC)));
endmodule

bind rst_pulse_gen rpg_checker #(
    .RELEASE_CYC(RELEASE_CYC), .MIN_CYC(MIN_CYC), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .por_n(por_n), .trig(trig), .state(state), .cnt(cnt),
    .rst_o(rst_o), .rst_n_o(rst_n_o), .reset_active(reset_active)
);

// File: tb/rst_pulse_gen_bench.sv
module rst_pulse_gen_bench;
    localparam int REL  = 20;
    localparam int MINC = 12;
    localparam int LAT  = 3;   // two sync flops + state flop
    localparam int K_EARLY = 5;
    localparam int K_LATE  = 15;
    // Request seen by the state at edge k+3; edges 4..k+2 decrement: REL-k+1 left
    localparam int REM_EARLY = REL - K_EARLY + 1;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic supply_low = 1'b1;
    logic mr_n = 1'b1;
    logic rst_n_o, rst_o, reset_active;

    int checks = 0;
    int errors = 0;
    int pol_bad = 0;

    always #4ns clk = ~clk;

    rst_pulse_gen #(.RELEASE_CYC(REL), .MIN_CYC(MINC), .SYNC_STAGES(2)) u_rst_pulse_gen (
        .clk(clk), .por_n(por_n), .supply_low(supply_low), .mr_n(mr_n),
        .rst_n_o(rst_n_o), .rst_o(rst_o), .reset_active(reset_active)
    );

    // R8 monitor
    always @(negedge clk) begin
        if ((rst_o !== ~rst_n_o) || (reset_active !== rst_o)) pol_bad++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges_until(input logic val, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rst_n_o !== val && n < 2000);
    endtask

    task automatic t_power_on();
        int n;
        repeat (4) @(negedge clk);
        check(rst_n_o === 1'b0, "R1 reset during por", int'(rst_n_o), 0);
        por_n = 1'b1;
        repeat (2) @(negedge clk);
        check(rst_n_o === 1'b0, "R1 reset after por", int'(rst_n_o), 0);
        repeat (30) @(negedge clk);
        check(rst_n_o === 1'b0, "R2 held while supply low", int'(rst_n_o), 0);
        supply_low = 1'b0;
        edges_until(1'b1, n);
        check(n == REL + LAT, "R3 release delay", n, REL + LAT);
    endtask

    task automatic t_glitch_from_run();
        int n;
        repeat (5) @(negedge clk);
        supply_low = 1'b1;
        @(negedge clk);
        supply_low = 1'b0;
        n = 1;
        while (rst_n_o !== 1'b0 && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(n == LAT, "R9 assert latency", n, LAT);
        edges_until(1'b1, n);
        check(n + LAT - 1 == REL + LAT, "R6 glitch full pulse", n + LAT - 1, REL + LAT);
    endtask

    task automatic start_pulse();
        supply_low = 1'b1;
        repeat (6) @(negedge clk);
        supply_low = 1'b0;
    endtask

    task automatic t_brownout(input int k, input int exp, input string req, input bit use_mr);
        int n;
        start_pulse();
        repeat (k) @(negedge clk);
        if (use_mr) mr_n = 1'b0; else supply_low = 1'b1;
        @(negedge clk);
        mr_n = 1'b1;
        supply_low = 1'b0;
        edges_until(1'b1, n);
        check(n == exp, req, n, exp);
    endtask

    task automatic t_manual_from_run();
        int n;
        repeat (5) @(negedge clk);
        mr_n = 1'b0;
        n = 0;
        while (rst_n_o !== 1'b0 && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(n == LAT, "R7 mr assert latency", n, LAT);
        repeat (40) @(negedge clk);
        check(rst_n_o === 1'b0, "R7 held while mr low", int'(rst_n_o), 0);
        mr_n = 1'b1;
        edges_until(1'b1, n);
        check(n == REL + LAT, "R7 mr release delay", n, REL + LAT);
    endtask

    initial begin : watchdog
        #(8ns * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_power_on();
        t_glitch_from_run();
        t_brownout(K_EARLY, REM_EARLY + LAT, "R5 early brownout keeps count", 1'b0);
        t_brownout(K_LATE, MINC + LAT, "R4 late brownout stretches to min", 1'b0);
        t_manual_from_run();
        t_brownout(K_LATE, MINC + LAT, "R7 mr tap stretches to min", 1'b1);
        repeat (3) @(negedge clk);
        check(reset_active === 1'b0 && rst_o === 1'b0, "R8 released outputs",
              int'(reset_active), 0);
        check(pol_bad == 0, "R8 polarity pair", pol_bad, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule